// File: doc/BRIEF.md
# Bus-Lane-Aware Data Break Comparator

This block is the data-qualification stage of an on-chip break unit. The CPU's internal data bus is 16 bits wide, but which half carries the byte being observed depends on three things. These are the access size, the parity of the address, and the width of the region being addressed. The region can be memory, I/O with an 8-bit bus, or I/O with a 16-bit bus. A small group of 16-bit I/O registers follows its own rule for byte accesses. The block resolves the carrying lane for every bus cycle. It then compares that lane, or the whole bus, against a programmable 16-bit reference.

A 2-bit condition field chooses between four settings: no data qualification, match on the low reference byte, match on the high reference byte, and match on the full word. The block combines the data match with an externally decoded address hit and a cycle-valid strobe. From these it produces a registered, single-cycle break request. A word access to 8-bit I/O reaches the block as two separate byte cycles, and each cycle is judged on its own.

Top module: `brk_data_cmp`

## Requirements
- R1: A synchronous active-high reset sets the condition field to 00, the reference to 0x0000 and `brk_req` to 0.
- R2: A write to the condition field (`cfg_cond_we`) or to the reference (`cfg_ref_we`) shows up on `cfg_cond_rd` or `cfg_ref_rd` one clock later, and governs matching from that cycle on.
- R3: With condition 00, `data_hit` is 1 whatever the bus data, so a break depends on the address hit alone.
- R4: Condition 01 compares reference bits [7:0] with the selected lane, and condition 10 compares reference bits [15:8] with it. The upper lane is bus bits [15:8] and the lower lane is bus bits [7:0].
- R5: Condition 11 requires all 16 bus bits to equal the reference, whatever the lane selection.
- R6: In memory space (`bus_space` 00, and 11 treated the same way), a word access selects the upper lane at an even address and the lower lane at an odd one. A byte access always selects the upper lane.
- R7: In 8-bit I/O space (`bus_space` 01), the upper lane is selected for every access, word or byte, at either parity.
- R8: In 16-bit I/O space (`bus_space` 10), addresses inside the special ranges 0xFFFF96–0xFFFF97 and 0xFFFFB8–0xFFFFBB select the lane by parity for word accesses. Byte accesses to these addresses always select the upper lane.
- R9: Other 16-bit I/O addresses select the lane by parity for both word and byte accesses: upper at even, lower at odd.
- R10: `brk_req` is 1 for exactly the clock after a cycle in which `bus_valid`, `addr_hit` and `data_hit` are all 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cond_we | input | 1 | Write strobe for the condition field |
| cfg_cond_wd | input | 2 | Condition field write data |
| cfg_ref_we | input | 1 | Write strobe for the reference |
| cfg_ref_wd | input | 16 | Reference write data |
| cfg_cond_rd | output | 2 | Current condition field |
| cfg_ref_rd | output | 16 | Current reference |
| bus_valid | input | 1 | Qualified bus cycle strobe |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_addr | input | 24 | Access address |
| bus_space | input | 2 | 00 memory, 01 8-bit I/O, 10 16-bit I/O, 11 memory |
| bus_data | input | 16 | Internal data bus |
| addr_hit | input | 1 | Address match from the address comparator |
| data_hit | output | 1 | Combinational data match for the current cycle |
| brk_req | output | 1 | Registered break request pulse |

## Verification
The hardest case to reach is a byte access to 16-bit I/O whose address sits right at the edge of a special range. On one side of the edge the byte is read from the upper lane; on the other side it is read from the lower lane. The stimulus targets 0xFFFF97, 0xFFFFB9 and 0xFFFF99. It places the reference byte in only one lane, so a match proves which lane was chosen and a miss shows that the other lane was ignored. Word accesses to 8-bit I/O at odd addresses are driven the same way, with the data in the lower lane only, to show that those cycles never select the lower lane.

// File: rtl/brk_data_pkg.sv
package brk_data_pkg;
    typedef enum logic [1:0] {
        SP_MEM  = 2'b00,
        SP_IO8  = 2'b01,
        SP_IO16 = 2'b10,
        SP_RSV  = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        CMP_OFF  = 2'b00,
        CMP_LO   = 2'b01,
        CMP_HI   = 2'b10,
        CMP_WORD = 2'b11
    } cond_e;

    typedef enum logic {
        LANE_UP = 1'b0,
        LANE_DN = 1'b1
    } lane_e;
endpackage

// File: rtl/brk_lane_sel.sv
module brk_lane_sel
    import brk_data_pkg::*;
#(
    parameter int AW     = 24,
    parameter int N_SPEC = 2,
    parameter logic [N_SPEC-1:0][AW-1:0] SPEC_LO = {24'hFFFFB8, 24'hFFFF96},
    parameter logic [N_SPEC-1:0][AW-1:0] SPEC_HI = {24'hFFFFBB, 24'hFFFF97}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          word,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    space,
    output lane_e         lane
);
    logic [N_SPEC-1:0] in_rng;
    logic              special;
    lane_e             by_par;

    for (genvar i = 0; i < N_SPEC; i++) begin : g_rng
        assign in_rng[i] = (addr >= SPEC_LO[i]) && (addr <= SPEC_HI[i]);
    end

    assign special = |in_rng;
    assign by_par  = addr[0] ? LANE_DN : LANE_UP;

    always_comb begin
        lane = LANE_UP;
        unique case (space_e'(space))
            SP_IO8:  lane = LANE_UP;
            SP_IO16: lane = (word || !special) ? by_par : LANE_UP;
            default: lane = word ? by_par : LANE_UP;
        endcase
    end

    // R7: narrow I/O never uses the lower lane
    a_r7_io8_upper: assert property (@(posedge clk) disable iff (rst)
        (space == 2'b01) |-> (lane == LANE_UP));
    // R6: memory byte access sits on the upper lane
    a_r6_mem_byte_upper: assert property (@(posedge clk) disable iff (rst)
        (!space[1] || space[0]) && !word |-> (lane == LANE_UP));
    // R6: memory word access at odd address uses lower lane
    a_r6_mem_word_odd: assert property (@(posedge clk) disable iff (rst)
        (space != 2'b01) && (space != 2'b10) && word && addr[0] |-> (lane == LANE_DN));
endmodule

// File: rtl/brk_data_match.sv
module brk_data_match
    import brk_data_pkg::*;
#(
    parameter int DW = 16,
    localparam int BW = DW / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cond,
    input  lane_e         lane,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] ref_v,
    output logic          hit
);
    logic [BW-1:0] lane_byte;
    logic [BW-1:0] ref_byte;

    assign lane_byte = (lane == LANE_DN) ? data[BW-1:0] : data[DW-1:BW];
    assign ref_byte  = (cond_e'(cond) == CMP_HI) ? ref_v[DW-1:BW] : ref_v[BW-1:0];

    always_comb begin
        hit = 1'b1;
        unique case (cond_e'(cond))
            CMP_OFF:  hit = 1'b1;
            CMP_WORD: hit = (data == ref_v);
            default:  hit = (lane_byte == ref_byte);
        endcase
    end

    // R5: full-word mode match implies bus equals reference
    a_r5_word_exact: assert property (@(posedge clk) disable iff (rst)
        (cond == 2'b11) && hit |-> (data == ref_v));
    // R4: byte mode match implies the chosen reference byte is on some lane
    a_r4_byte_present: assert property (@(posedge clk) disable iff (rst)
        (cond == 2'b10) && hit |-> (data[DW-1:BW] == ref_v[DW-1:BW]) || (data[BW-1:0] == ref_v[DW-1:BW]));
endmodule

// File: rtl/brk_data_cmp.sv
module brk_data_cmp
    import brk_data_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_cond_we,
    input  logic [1:0]    cfg_cond_wd,
    input  logic          cfg_ref_we,
    input  logic [DW-1:0] cfg_ref_wd,
    output logic [1:0]    cfg_cond_rd,
    output logic [DW-1:0] cfg_ref_rd,
    input  logic          bus_valid,
    input  logic          bus_word,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_space,
    input  logic [DW-1:0] bus_data,
    input  logic          addr_hit,
    output logic          data_hit,
    output logic          brk_req
);
    typedef struct packed {
        logic [1:0]    cond;
        logic [DW-1:0] ref_v;
        logic          brk;
    } state_t;

    state_t st_d, st_q;
    lane_e  lane;

    brk_lane_sel #(.AW(AW)) u_lane (
        .clk   (clk),
        .rst   (rst),
        .word  (bus_word),
        .addr  (bus_addr),
        .space (bus_space),
        .lane  (lane)
    );

    brk_data_match #(.DW(DW)) u_match (
        .clk   (clk),
        .rst   (rst),
        .cond  (st_q.cond),
        .lane  (lane),
        .data  (bus_data),
        .ref_v (st_q.ref_v),
        .hit   (data_hit)
    );

    always_comb begin
        st_d     = st_q;
        if (cfg_cond_we) st_d.cond  = cfg_cond_wd;
        if (cfg_ref_we)  st_d.ref_v = cfg_ref_wd;
        st_d.brk = bus_valid && addr_hit && data_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg_cond_rd = st_q.cond;
    assign cfg_ref_rd  = st_q.ref_v;
    assign brk_req     = st_q.brk;

    // R1: reset clears configuration and request
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cfg_cond_rd == 2'b00) && (cfg_ref_rd == '0) && !brk_req);
    // R3: disabled comparison always matches
    a_r3_off_true: assert property (@(posedge clk) disable iff (rst)
        (cfg_cond_rd == 2'b00) |-> data_hit);
    // R10: qualified cycle raises the request next clock
    a_r10_req_follows: assert property (@(posedge clk) disable iff (rst)
        bus_valid && addr_hit && data_hit |=> brk_req);
    // R10: no request without valid address hit
    a_r10_req_gated: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && addr_hit) |=> !brk_req);
    // R2: written condition visible next clock
    a_r2_cond_wr: assert property (@(posedge clk) disable iff (rst)
        cfg_cond_we |=> (cfg_cond_rd == $past(cfg_cond_wd)));
endmodule

// File: tb/sim_brk_data_cmp.sv
module sim_brk_data_cmp;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_cond_we, cfg_ref_we;
    logic [1:0]  cfg_cond_wd;
    logic [15:0] cfg_ref_wd;
    logic [1:0]  cfg_cond_rd;
    logic [15:0] cfg_ref_rd;
    logic        bus_valid, bus_word, addr_hit;
    logic [23:0] bus_addr;
    logic [1:0]  bus_space;
    logic [15:0] bus_data;
    logic        data_hit, brk_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brk_data_cmp u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        bus_valid = 0; bus_word = 0; bus_addr = '0; bus_space = 2'b00;
        bus_data = '0; addr_hit = 0; cfg_cond_we = 0; cfg_ref_we = 0;
        cfg_cond_wd = '0; cfg_ref_wd = '0;
    endtask

    task automatic cfg(input logic [1:0] c, input logic [15:0] r);
        @(negedge clk);
        cfg_cond_we = 1; cfg_cond_wd = c; cfg_ref_we = 1; cfg_ref_wd = r;
        @(negedge clk);
        cfg_cond_we = 0; cfg_ref_we = 0;
    endtask

    // one bus cycle: data_hit checked same cycle, brk_req one clock later
    task automatic cyc(input string tag, input logic v, input logic w, input logic [23:0] a,
                       input logic [1:0] sp, input logic [15:0] d, input logic ah,
                       input logic exp_hit);
        @(negedge clk);
        bus_valid = v; bus_word = w; bus_addr = a; bus_space = sp; bus_data = d; addr_hit = ah;
        #1 chk({tag, " data_hit"}, 32'(data_hit), 32'(exp_hit));
        @(negedge clk);
        chk({tag, " brk_req"}, 32'(brk_req), 32'(v && ah && exp_hit));
        bus_valid = 0; addr_hit = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cond", 32'(cfg_cond_rd), 0);
        chk("R1 ref", 32'(cfg_ref_rd), 0);
        chk("R1 brk", 32'(brk_req), 0);
    endtask

    task automatic t_cfg();
        cfg(2'b01, 16'h1234);
        chk("R2 cond rd", 32'(cfg_cond_rd), 1);
        chk("R2 ref rd", 32'(cfg_ref_rd), 32'h1234);
    endtask

    task automatic t_off();
        cfg(2'b00, 16'h1234);
        cyc("R3 off any", 1, 1, 24'h000100, 2'b00, 16'hBEEF, 1, 1);
        cyc("R3 off io", 1, 0, 24'hFFFF01, 2'b01, 16'h0000, 1, 1);
    endtask

    task automatic t_mem();
        cfg(2'b10, 16'h1234);
        cyc("R6 R4 word even up", 1, 1, 24'h000200, 2'b00, 16'h1200, 1, 1);
        cyc("R6 word odd up miss", 1, 1, 24'h000201, 2'b00, 16'h1200, 1, 0);
        cyc("R6 word odd down", 1, 1, 24'h000201, 2'b00, 16'h0012, 1, 1);
        cyc("R6 byte odd up", 1, 0, 24'h000201, 2'b00, 16'h1200, 1, 1);
        cyc("R6 rsv space byte odd", 1, 0, 24'h000203, 2'b11, 16'h1200, 1, 1);
        cfg(2'b01, 16'h1234);
        cyc("R4 lo byte odd word", 1, 1, 24'h000301, 2'b00, 16'h0034, 1, 1);
        cyc("R4 lo vs hi miss", 1, 1, 24'h000300, 2'b00, 16'h1200, 1, 0);
    endtask

    task automatic t_io8();
        cfg(2'b01, 16'h1234);
        cyc("R7 byte odd up", 1, 0, 24'hFFFE01, 2'b01, 16'h3400, 1, 1);
        cyc("R7 word odd not down", 1, 1, 24'hFFFE01, 2'b01, 16'h0034, 1, 0);
        cyc("R7 word odd up", 1, 1, 24'hFFFE01, 2'b01, 16'h3400, 1, 1);
    endtask

    task automatic t_io16();
        cfg(2'b01, 16'h1234);
        cyc("R8 special byte odd up", 1, 0, 24'hFFFF97, 2'b10, 16'h3400, 1, 1);
        cyc("R8 special word odd down", 1, 1, 24'hFFFFBB, 2'b10, 16'h0034, 1, 1);
        cyc("R8 special byte odd not down", 1, 0, 24'hFFFFB9, 2'b10, 16'h0034, 1, 0);
        cyc("R9 other byte odd down", 1, 0, 24'hFFFF99, 2'b10, 16'h0034, 1, 1);
        cyc("R9 other byte even up", 1, 0, 24'hFFFF98, 2'b10, 16'h3400, 1, 1);
        cyc("R9 other word odd down", 1, 1, 24'hFFFFBD, 2'b10, 16'h0034, 1, 1);
    endtask

    task automatic t_word();
        cfg(2'b11, 16'h1234);
        cyc("R5 exact", 1, 1, 24'h000400, 2'b00, 16'h1234, 1, 1);
        cyc("R5 one bit off", 1, 1, 24'h000400, 2'b00, 16'h1235, 1, 0);
        cyc("R5 odd lane ignored", 1, 0, 24'hFFFF99, 2'b10, 16'h1234, 1, 1);
    endtask

    task automatic t_req();
        cfg(2'b00, 16'h0000);
        cyc("R10 no valid", 0, 1, 24'h000500, 2'b00, 16'h0, 1, 1);
        cyc("R10 no addr hit", 1, 1, 24'h000500, 2'b00, 16'h0, 0, 1);
        cyc("R10 pulse", 1, 1, 24'h000500, 2'b00, 16'h0, 1, 1);
        @(negedge clk);
        chk("R10 pulse single", 32'(brk_req), 0);
    endtask

    task automatic t_rst_mid();
        cfg(2'b11, 16'hA5A5);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R1 mid cond", 32'(cfg_cond_rd), 0);
        chk("R1 mid ref", 32'(cfg_ref_rd), 0);
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_cfg();
        t_off();
        t_mem();
        t_io8();
        t_io16();
        t_word();
        t_req();
        t_rst_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule